// File: doc/BRIEF.md
# Clock-Stop SPI Master Serial Port

This block is the master side of a synchronous serial link. A one-cycle start request loads a parallel word. The block then pulls an active-low slave-select line low and runs a shift clock derived from the system clock. It moves the word out on the data-out line, most significant bit first, and collects the same number of bits from the data-in line. Between words the shift clock is held low and does not toggle, and the data-out driver is switched off.

The shift-clock period comes from a divider setting: it is one more than the setting, counted in system-clock cycles. The split between the high and low phases depends on whether the setting is odd or even, so even settings give an uneven duty cycle. The word length is a configuration input, clamped into a legal range. When the word is complete the block releases slave-select, presents the received word and raises a one-cycle done pulse. A busy flag covers the transfer. The divider and length inputs are captured when the start request is accepted.

Top module: `spi_cs_master`

## Requirements
- R1: A synchronous reset, applied at any time including during a transfer, forces `sclk` to 0, `ss_n` to 1, `mosi_oe` to 0, `done` to 0 and `busy` to 0.
- R2: The shift-clock period is 1 + `div` system cycles. A `div` of 0 is treated as 1, which gives a period of 2. From the fall of `ss_n` to its rise there are exactly n·(period) + L system cycles, where n is the word length and L is the low-phase length.
- R3: Phase lengths follow the parity of the divider. For odd `div`, low = high = (1 + `div`)/2. For even nonzero `div`, low = `div`/2 and high = `div`/2 + 1. For `div` = 0 the clock has one cycle low and one cycle high.
- R4: `sclk` is 0 whenever `ss_n` is 1. It toggles only while a word is moving and produces exactly n rising edges per transfer.
- R5: `ss_n` falls with `sclk` low. It stays low for exactly one low phase (L cycles) before the first rising edge of `sclk`.
- R6: Data leaves MSB first. Bit n-1 of `tx_word` is on `mosi` with `mosi_oe` = 1 from the cycle `ss_n` falls. Each later rising edge of `sclk` moves on to the next lower bit, so bit 0 is the last bit sent.
- R7: `miso` is sampled in the system cycle where `sclk` falls. The first sample becomes bit n-1 of `rx_word`. Bits above n-1 of `rx_word` read 0.
- R8: `mosi_oe` is 0 while `ss_n` is 1. It drops to 0 at the final falling edge of `sclk`, which ends bit 0.
- R9: After the final falling edge, `ss_n` stays low for one more low phase and then returns high. In that same cycle `done` is 1 for exactly one cycle and `rx_word` holds the new word.
- R10: The word length n is `word_len`, clamped to the range 8 to 32. Values below 8 give 8 bits and values above 32 give 32 bits. Bits of `tx_word` above n-1 are not sent.
- R11: `busy` is 1 from the cycle after `start` is accepted until `ss_n` returns high. A `start` raised while `busy` is 1 is ignored and does not begin a second transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_word | input | 32 | Word to send, right-aligned |
| div | input | 8 | Shift-clock divider setting |
| word_len | input | 6 | Requested word length in bits |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Shift clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave, valid when `mosi_oe` is 1 |
| mosi_oe | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| rx_word | output | 32 | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| busy | output | 1 | Transfer in progress |

## Verification
The bench measures every high and low run of `sclk` at divider settings of 0, 1, 2, 3 and 4. An even setting is the case that a design with a fixed 50 % duty cycle, or with the low and high lengths swapped, would get wrong. A design without the zero-divider guard would hang with `sclk` stuck. It checks that the first bit is already on `mosi` when `ss_n` falls and that the final low phase is present after the last falling edge. A design that shifted on the first rising edge would lose the MSB. A design that dropped `ss_n` at the falling edge would clip the last bit. Word lengths of 5 and 40 test the clamp, where a missing bound would send a short word or run a counter past its end. A second `start` during a transfer tests the busy interlock, which a broken design would answer with an extra select pulse or a corrupted word.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

   // transfer sequencer states
   typedef enum logic [2:0] {
      ST_IDLE,   // select high, clock stopped
      ST_LEAD,   // select low, first bit driven, clock low
      ST_HIGH,   // clock high phase of a bit
      ST_LOW,    // clock low phase between bits
      ST_TAIL    // clock low after the last bit, select still low
   } xfer_state_t;

endpackage

// File: rtl/spi_cs_phase_gen.sv
module spi_cs_phase_gen #(
   parameter int DIV_W = 8,
   localparam int CNT_W = DIV_W + 1
) (
   input  logic [DIV_W-1:0] div,
   output logic [CNT_W-1:0] lo_len,
   output logic [CNT_W-1:0] hi_len
);

   logic [CNT_W-1:0] div_eff;
   logic [CNT_W-1:0] period;

   always_comb begin
      // a zero setting cannot give a one-cycle period, so it runs as one
      div_eff = (div == '0) ? CNT_W'(1) : {1'b0, div};
      period  = div_eff + CNT_W'(1);
      if (div_eff[0]) begin
         lo_len = period >> 1;
      end else begin
         lo_len = div_eff >> 1;
      end
      hi_len = period - lo_len;
   end

endmodule

// File: rtl/spi_cs_phase_timer.sv
module spi_cs_phase_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
   parameter int MAX_W = 32,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [MAX_W-1:0] tx_word,
   input  logic [LEN_W-1:0] align,
   input  logic             tx_step,
   input  logic             rx_step,
   input  logic             miso,
   output logic             mosi_bit,
   output logic [MAX_W-1:0] rx_shift
);

   logic [MAX_W-1:0] tx_shift;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_shift <= '0;
      end else if (load) begin
         tx_shift <= tx_word << align;   // left-align so the MSB sits on top
      end else if (tx_step) begin
         tx_shift <= {tx_shift[MAX_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_shift <= '0;
      end else if (load) begin
         rx_shift <= '0;
      end else if (rx_step) begin
         rx_shift <= {rx_shift[MAX_W-2:0], miso};
      end
   end

   assign mosi_bit = tx_shift[MAX_W-1];

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
   import spi_cs_pkg::*;
#(
   parameter int MAX_W = 32,
   parameter int MIN_W = 8,
   parameter int DIV_W = 8,
   localparam int LEN_W = $clog2(MAX_W + 1),
   localparam int CNT_W = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [MAX_W-1:0] tx_word,
   input  logic [DIV_W-1:0] div,
   input  logic [LEN_W-1:0] word_len,
   input  logic             miso,
   output logic             sclk,
   output logic             ss_n,
   output logic             mosi,
   output logic             mosi_oe,
   output logic [MAX_W-1:0] rx_word,
   output logic             done,
   output logic             busy
);

   generate
      if (MIN_W < 2 || MIN_W > MAX_W) begin : g_bad_len
         $error("spi_cs_master: MIN_W must lie in 2..MAX_W");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("spi_cs_master: DIV_W must be at least 2");
      end
   endgenerate

   xfer_state_t      state;
   logic [CNT_W-1:0] lo_len, hi_len;
   logic [CNT_W-1:0] lo_q, hi_q;
   logic [LEN_W-1:0] len_eff, align, bits_left;
   logic             tmr_ld, tmr_exp;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, tx_step, rx_step;
   logic [MAX_W-1:0] rx_shift;
   logic             sclk_q, ss_n_q, oe_q, done_q;
   logic [MAX_W-1:0] rx_q;

   // word length clamp
   always_comb begin
      if (word_len < LEN_W'(MIN_W)) begin
         len_eff = LEN_W'(MIN_W);
      end else if (word_len > LEN_W'(MAX_W)) begin
         len_eff = LEN_W'(MAX_W);
      end else begin
         len_eff = word_len;
      end
      align = LEN_W'(MAX_W) - len_eff;
   end

   spi_cs_phase_gen #(.DIV_W(DIV_W)) u_phase (
      .div    (div),
      .lo_len (lo_len),
      .hi_len (hi_len)
   );

   spi_cs_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .ld      (tmr_ld),
      .ld_val  (tmr_val),
      .expired (tmr_exp)
   );

   spi_cs_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .load     (sh_load),
      .tx_word  (tx_word),
      .align    (align),
      .tx_step  (tx_step),
      .rx_step  (rx_step),
      .miso     (miso),
      .mosi_bit (mosi),
      .rx_shift (rx_shift)
   );

   // phase timer reloads and shift strobes
   always_comb begin
      tmr_ld  = 1'b0;
      tmr_val = lo_q - CNT_W'(1);
      sh_load = 1'b0;
      tx_step = 1'b0;
      rx_step = 1'b0;
      case (state)
         ST_IDLE: begin
            if (start) begin
               tmr_ld  = 1'b1;
               tmr_val = lo_len - CNT_W'(1);
               sh_load = 1'b1;
            end
         end
         ST_LEAD: begin
            if (tmr_exp) begin
               tmr_ld  = 1'b1;
               tmr_val = hi_q - CNT_W'(1);
            end
         end
         ST_HIGH: begin
            if (tmr_exp) begin
               tmr_ld  = 1'b1;
               tmr_val = lo_q - CNT_W'(1);
               rx_step = 1'b1;       // falling edge: capture
            end
         end
         ST_LOW: begin
            if (tmr_exp) begin
               tmr_ld  = 1'b1;
               tmr_val = hi_q - CNT_W'(1);
               tx_step = 1'b1;       // rising edge: next bit out
            end
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         sclk_q    <= 1'b0;
         ss_n_q    <= 1'b1;
         oe_q      <= 1'b0;
         done_q    <= 1'b0;
         rx_q      <= '0;
         bits_left <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_LEAD;
                  ss_n_q    <= 1'b0;
                  oe_q      <= 1'b1;
                  lo_q      <= lo_len;
                  hi_q      <= hi_len;
                  bits_left <= len_eff - LEN_W'(1);
               end
            end
            ST_LEAD: begin
               if (tmr_exp) begin
                  sclk_q <= 1'b1;
                  state  <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tmr_exp) begin
                  sclk_q <= 1'b0;
                  if (bits_left == '0) begin
                     state <= ST_TAIL;
                     oe_q  <= 1'b0;
                  end else begin
                     state <= ST_LOW;
                  end
               end
            end
            ST_LOW: begin
               if (tmr_exp) begin
                  sclk_q    <= 1'b1;
                  bits_left <= bits_left - LEN_W'(1);
                  state     <= ST_HIGH;
               end
            end
            ST_TAIL: begin
               if (tmr_exp) begin
                  ss_n_q <= 1'b1;
                  done_q <= 1'b1;
                  rx_q   <= rx_shift;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sclk    = sclk_q;
   assign ss_n    = ss_n_q;
   assign mosi_oe = oe_q;
   assign done    = done_q;
   assign rx_word = rx_q;
   assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
   input logic clk,
   input logic rst,
   input logic sclk,
   input logic ss_n,
   input logic mosi_oe,
   input logic done,
   input logic busy
);

   // R4: clock held low whenever the slave is deselected
   a_r4_clock_stopped: assert property (@(posedge clk) disable iff (rst)
      ss_n |-> !sclk);

   // R8: data driver off while deselected
   a_r8_driver_off: assert property (@(posedge clk) disable iff (rst)
      ss_n |-> !mosi_oe);

   // R5: select falls with clock low and the first bit already driven
   a_r5_select_lead: assert property (@(posedge clk) disable iff (rst)
      $fell(ss_n) |-> (!sclk && mosi_oe));

   // R9: done comes with the release of select, for one cycle only
   a_r9_done_on_release: assert property (@(posedge clk) disable iff (rst)
      $rose(ss_n) |-> done);
   a_r9_done_needs_release: assert property (@(posedge clk) disable iff (rst)
      done |-> ss_n);
   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R11: busy covers the whole selected interval
   a_r11_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
      !ss_n |-> busy);

endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sclk    (sclk),
   .ss_n    (ss_n),
   .mosi_oe (mosi_oe),
   .done    (done),
   .busy    (busy)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] tx_word = '0;
   logic [7:0]  div = '0;
   logic [5:0]  word_len = 6'd8;
   logic        miso = 1'b0;
   logic        sclk, ss_n, mosi, mosi_oe, done, busy;
   logic [31:0] rx_word;

   always #10 clk = ~clk;   // 50 MHz

   spi_cs_master dut_i (
      .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .div(div),
      .word_len(word_len), .miso(miso), .sclk(sclk), .ss_n(ss_n),
      .mosi(mosi), .mosi_oe(mosi_oe), .rx_word(rx_word), .done(done),
      .busy(busy)
   );

   int checks = 0;
   int fails  = 0;

   // expectations for the running transfer
   int          exp_n = 8, exp_lo = 1, exp_hi = 1;
   logic [31:0] exp_tx = '0, slv = '0;

   // monitor results
   int          run, rise_cnt, sel_cyc, xfer_cnt, done_seen, bit_i;
   int          err_hi, err_lo, err_tail, err_first, err_oe, err_idle, err_done;
   logic [31:0] mosi_cap;
   logic        prev_ss = 1'b1, prev_sclk = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // bench-side slave and line observer, sampled mid-cycle
   always @(negedge clk) begin
      if (rst) begin
         prev_ss   = 1'b1;
         prev_sclk = 1'b0;
      end else begin
         if (done) begin
            done_seen++;
            if (!(ss_n && !prev_ss)) err_done++;
         end
         if (ss_n) begin
            if (mosi_oe || sclk) err_idle++;
            if (!prev_ss && (prev_sclk || run != exp_lo)) err_tail++;
         end else begin
            sel_cyc++;
            if (prev_ss) begin
               xfer_cnt++;
               run      = 1;
               rise_cnt = 0;
               mosi_cap = '0;
               bit_i    = exp_n - 1;
               if (sclk || !mosi_oe || mosi !== exp_tx[exp_n-1]) err_first++;
               miso = slv[bit_i];
            end else if (sclk != prev_sclk) begin
               if (sclk) begin
                  if (run != exp_lo) err_lo++;
                  rise_cnt++;
                  mosi_cap = {mosi_cap[30:0], mosi};
                  if (!mosi_oe) err_oe++;
               end else begin
                  if (run != exp_hi) err_hi++;
                  bit_i--;
                  if (bit_i >= 0) miso = slv[bit_i];
               end
               run = 1;
            end else begin
               run++;
            end
            if (!sclk && rise_cnt == exp_n && mosi_oe) err_oe++;
         end
         prev_ss   = ss_n;
         prev_sclk = sclk;
      end
   end

   function automatic int clamp_len(input int wl);
      if (wl < 8) return 8;
      if (wl > 32) return 32;
      return wl;
   endfunction

   function automatic logic [31:0] low_mask(input int n);
      longint m;
      m = (64'd1 << n) - 1;
      return m[31:0];
   endfunction

   task automatic clear_monitor();
      sel_cyc = 0; xfer_cnt = 0; done_seen = 0; rise_cnt = 0;
      err_hi = 0; err_lo = 0; err_tail = 0; err_first = 0;
      err_oe = 0; err_idle = 0; err_done = 0;
   endtask

   task automatic setup(input int d, input int wl, input logic [31:0] tx, input logic [31:0] sw);
      int per;
      per    = (d == 0) ? 2 : d + 1;
      exp_n  = clamp_len(wl);
      exp_lo = (d == 0) ? 1 : ((d % 2 == 1) ? per / 2 : d / 2);
      exp_hi = per - exp_lo;
      exp_tx = tx;
      slv    = sw;
      clear_monitor();
      @(negedge clk);
      div      = d[7:0];
      word_len = wl[5:0];
      tx_word  = tx;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000 && done_seen == 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic verify(input string tag);
      logic [31:0] m;
      m = low_mask(exp_n);
      check(done_seen == 1 && err_done == 0, {tag, " R9 done pulse"}, done_seen, 1);
      check(rise_cnt == exp_n, {tag, " R4 R10 edge count"}, rise_cnt, exp_n);
      check(mosi_cap == (exp_tx & m), {tag, " R6 sent word"}, mosi_cap, exp_tx & m);
      check(rx_word == (slv & m), {tag, " R7 received word"}, rx_word, slv & m);
      check(err_hi == 0 && err_lo == 0, {tag, " R3 phase lengths"}, err_hi + err_lo, 0);
      check(sel_cyc == exp_n * (exp_lo + exp_hi) + exp_lo, {tag, " R2 select window"},
            sel_cyc, exp_n * (exp_lo + exp_hi) + exp_lo);
      check(err_first == 0, {tag, " R5 lead phase and first bit"}, err_first, 0);
      check(err_tail == 0, {tag, " R9 tail phase"}, err_tail, 0);
      check(err_oe == 0 && err_idle == 0, {tag, " R8 driver enable"}, err_oe + err_idle, 0);
      check(busy == 1'b0 && ss_n == 1'b1, {tag, " R11 idle after done"}, busy, 0);
   endtask

   task automatic xfer(input int d, input int wl, input logic [31:0] tx,
                       input logic [31:0] sw, input string tag);
      setup(d, wl, tx, sw);
      wait_done();
      verify(tag);
   endtask

   task automatic test_reset_state();
      @(negedge clk);
      check(ss_n == 1'b1 && sclk == 1'b0, "R1 reset select and clock", {ss_n, sclk}, 2'b10);
      check(mosi_oe == 1'b0 && done == 1'b0 && busy == 1'b0, "R1 reset enables",
            {mosi_oe, done, busy}, 0);
   endtask

   task automatic test_busy_block();
      setup(2, 12, 32'h0000_0A5C, 32'h0000_0F0F);
      repeat (7) @(negedge clk);
      check(busy == 1'b1, "R11 busy during transfer", busy, 1);
      tx_word = 32'hFFFF_FFFF;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      wait_done();
      verify("busy");
      repeat (20) @(negedge clk);
      check(xfer_cnt == 1 && ss_n == 1'b1, "R11 extra start ignored", xfer_cnt, 1);
   endtask

   task automatic test_mid_reset();
      setup(3, 16, 32'h0000_BEEF, 32'h0000_1234);
      repeat (15) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(ss_n == 1'b1 && sclk == 1'b0 && mosi_oe == 1'b0 && busy == 1'b0,
            "R1 reset during transfer", {ss_n, sclk, mosi_oe, busy}, 4'b1000);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset_state();
      rst = 1'b0;
      @(negedge clk);
      xfer(1, 8,  32'h0000_00A5, 32'h0000_003C, "div1_len8");
      xfer(2, 16, 32'h0000_C3A1, 32'h0000_5E71, "div2_len16");
      xfer(3, 13, 32'hFFFF_1ABC, 32'h0000_0F55, "div3_len13");
      xfer(4, 32, 32'h8000_0001, 32'hDEAD_BEEF, "div4_len32");
      xfer(0, 8,  32'h0000_0081, 32'h0000_00FF, "div0_R2");
      xfer(2, 5,  32'h0000_01E6, 32'h0000_0099, "short_R10");
      xfer(1, 40, 32'h1357_9BDF, 32'hF0E1_D2C3, "long_R10");
      test_busy_block();
      test_mid_reset();
      xfer(1, 9, 32'h0000_0155, 32'h0000_01AA, "after_reset_R1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule